// File: doc/BRIEF.md
# ROM-less CPU Boot Loader by Instruction Injection

This block brings up an 8-bit 6502-style processor whose memory is all RAM. At power-up there is no program to run, so the block takes over the data bus and hands the CPU a synthesized program, one bus cycle at a time. For each image record it injects a load-immediate of the byte, then a store-absolute to the record's target address. On the store's write cycle only, the block releases the bus and lets RAM respond, so the CPU's own write places the byte. Once the final record has been placed, the block gives the bus and memory back for good and resets the CPU. The CPU then starts from the vectors that were just loaded.

The block generates the CPU clock, the CPU reset and the two interrupt lines. It also drives a memory-disable line that keeps RAM and the I/O peripheral off the bus, and a write strobe qualified by the clock-high phase. Image records arrive on a valid/ready port as (16-bit address, byte, last flag). Records aimed at the I/O page are consumed but never written. The CPU address bus is not watched: every read while booting is answered from the injection sequence.

Top module: `boot_injector`

## Requirements
- R1: While `rst_n` is low, `cpu_res_n` is 0, `mem_dis` is 1, `done` is 0, `cpu_phi2` is 0 and `rec_ready` is 0.
- R2: `cpu_phi2` has a period of 2*CLK_HALF_DIV clocks. It is low for CLK_HALF_DIV clocks and then high for CLK_HALF_DIV clocks. A CPU bus cycle runs from one falling edge of `cpu_phi2` to the next.
- R3: After reset, `cpu_res_n` stays low for exactly RESET_CYCLES CPU cycles (RESET_CYCLES >= 2). During that time `bus_oe`=1, `mem_dis`=1 and `bus_dout`=0xEA.
- R4: The next 7 CPU cycles drive 0xEA five times, then ENTRY_VECTOR[7:0], then ENTRY_VECTOR[15:8]. `cpu_res_n` is high.
- R5: Each written record takes six CPU cycles. The bus carries 0xA9, the data byte, 0x8D, the address low byte and the address high byte, and the sixth cycle is the write.
- R6: On that write cycle `bus_oe`=0 and `mem_dis`=0. On every other cycle before handover both are 1.
- R7: `bus_dout`, `bus_oe`, `mem_dis` and `cpu_res_n` change only at a falling edge of `cpu_phi2`. They hold still through the whole high phase.
- R8: `ram_we_n` is low only while `cpu_phi2` is high, `cpu_rwb` is 0, `mem_dis` is 0 and the bus is released.
- R9: A record whose address is in 0xFE00-0xFEFF is accepted but never written. Its slot is filled by two cycles of 0xEA.
- R10: When no record is valid at a slot boundary, a two-cycle 0xEA slot is injected instead.
- R11: A record is taken on a clock where `rec_valid` and `rec_ready` are both high. `rec_ready` is a single-clock pulse that occurs only at a slot boundary. After the record with `rec_last`=1, `rec_ready` never rises again.
- R12: After the slot of the last record, `mem_dis` and `bus_oe` go to 0 for good. `cpu_res_n` is low for exactly RESET_CYCLES CPU cycles and then high, and `done` rises and stays high.
- R13: `cpu_irq_n` and `cpu_nmi_n` are held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_valid | input | 1 | Image record offered |
| rec_ready | output | 1 | Record taken this clock |
| rec_addr | input | 16 | Target address of record |
| rec_data | input | 8 | Byte to place |
| rec_last | input | 1 | Final record of the image |
| cpu_phi2 | output | 1 | CPU clock |
| cpu_res_n | output | 1 | CPU reset, active low |
| cpu_irq_n | output | 1 | CPU maskable interrupt, active low |
| cpu_nmi_n | output | 1 | CPU non-maskable interrupt, active low |
| cpu_rwb | input | 1 | CPU read/write, 0 = write |
| bus_dout | output | 8 | Byte offered on the data bus |
| bus_oe | output | 1 | Enables the `bus_dout` drivers |
| mem_dis | output | 1 | Holds RAM and I/O off the bus |
| ram_we_n | output | 1 | Clock-qualified RAM write strobe |
| done | output | 1 | Handover complete |

## Verification
The bench plays the CPU. It decodes every bus cycle into reset, wake-up, injected or idle slots, and drives the write line on the cycles a real CPU would. One image sweeps addresses across the whole map, including both edges of the I/O page, the page just below it and the vector bytes, with arithmetic data and a long pause in the record stream. This separates correct writes from wrong ordering, from hole leakage and from missing idle slots. A second image is almost all hole records and ends on a hole that carries the last flag, which checks that handover starts even when the final record produces no write.

// File: rtl/boot_inj_pkg.sv
// Package boot_inj_pkg: shared sequencer states, injected opcodes and
// the I/O page test. Assumes a 16-bit address space with one I/O page.
package boot_inj_pkg;
    typedef enum logic [2:0] {
        ST_PWR_RST,   // CPU held in reset after power-up
        ST_WAKE,      // CPU reset sequence, ends with vector fetch
        ST_INJECT,    // load-immediate / store-absolute pair
        ST_IDLE_NOP,  // two-cycle filler slot
        ST_HANDOVER,  // final reset with memory released
        ST_RUN        // normal operation
    } boot_state_t;

    localparam logic [7:0] OP_LDA_IMM = 8'hA9;
    localparam logic [7:0] OP_STA_ABS = 8'h8D;
    localparam logic [7:0] OP_NOP     = 8'hEA;
    localparam logic [7:0] IO_PAGE    = 8'hFE;
    localparam int WAKE_LAST   = 6;  // seven wake-up cycles
    localparam int INJECT_LAST = 5;  // six cycles per written record
    localparam int NOP_LAST    = 1;  // two cycles per filler slot

    // True when the address falls in the I/O page
    function automatic logic in_io_page(input logic [15:0] a);
        return a[15:8] == IO_PAGE;
    endfunction
endpackage

// File: rtl/phase_clock.sv
// Module phase_clock: divides clk into the CPU clock. Low for HALF_DIV
// clocks, then high for HALF_DIV clocks. cyc_start pulses in the clock
// whose edge drops phi2, which is where a new CPU bus cycle begins.
// Assumes HALF_DIV >= 1.
module phase_clock #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic phi2,
    output logic cyc_start
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // Count clocks within a phase and toggle phi2 at the end of each phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            phi2 <= 1'b0;
        end else if (cnt == CNT_LAST) begin
            cnt  <= '0;
            phi2 <= ~phi2;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the clock that ends the high phase
    assign cyc_start = phi2 && (cnt == CNT_LAST);
endmodule

// File: rtl/inject_seq.sv
// Module inject_seq: steps the boot sequence one CPU cycle at a time.
// It also takes image records at slot boundaries and holds the
// current record. Assumes cyc_start marks each CPU cycle boundary.
module inject_seq
    import boot_inj_pkg::*;
#(
    parameter int RESET_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    input  logic          rec_valid,
    input  logic [15:0]   rec_addr,
    input  logic [7:0]    rec_data,
    input  logic          rec_last,
    output logic          rec_ready,
    output boot_state_t   state,
    output logic [$clog2((RESET_CYCLES > 8) ? RESET_CYCLES : 8)-1:0] step,
    output logic [15:0]   hold_addr,
    output logic [7:0]    hold_data
);
    localparam int SW = $clog2((RESET_CYCLES > 8) ? RESET_CYCLES : 8);
    localparam logic [SW-1:0] RST_LAST = SW'(RESET_CYCLES - 1);

    logic pend_last;
    logic slot_end;

    // A slot ends after the vector fetch, a store write or a filler slot
    always_comb begin
        slot_end = ((state == ST_WAKE)     && (int'(step) == WAKE_LAST))   ||
                   ((state == ST_INJECT)   && (int'(step) == INJECT_LAST)) ||
                   ((state == ST_IDLE_NOP) && (int'(step) == NOP_LAST));
    end

    // Take a record only at a slot boundary and never after the last one
    assign rec_ready = cyc_start && slot_end && !pend_last;

    // Advance the state and step at each CPU cycle boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_PWR_RST;
            step      <= '0;
            pend_last <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else if (cyc_start) begin
            if (slot_end) begin
                step <= '0;
                if (pend_last) begin
                    state <= ST_HANDOVER;
                end else if (rec_valid) begin
                    hold_addr <= rec_addr;
                    hold_data <= rec_data;
                    pend_last <= rec_last;
                    state     <= in_io_page(rec_addr) ? ST_IDLE_NOP : ST_INJECT;
                end else begin
                    state <= ST_IDLE_NOP;
                end
            end else begin
                unique case (state)
                    ST_PWR_RST: begin
                        if (step == RST_LAST) begin
                            state <= ST_WAKE;
                            step  <= '0;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                    ST_HANDOVER: begin
                        if (step == RST_LAST) begin
                            state <= ST_RUN;
                            step  <= '0;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                    ST_RUN:  step <= '0;
                    default: step <= step + 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/bus_driver.sv
// Module bus_driver: decodes the sequencer position into the byte on
// the data bus, its enable, memory-disable and CPU reset. The logic is
// purely combinational from registers that change only at cycle starts.
module bus_driver
    import boot_inj_pkg::*;
#(
    parameter int          SW           = 3,
    parameter logic [15:0] ENTRY_VECTOR = 16'h0200
) (
    input  boot_state_t   state,
    input  logic [SW-1:0] step,
    input  logic [15:0]   hold_addr,
    input  logic [7:0]    hold_data,
    output logic [7:0]    bus_dout,
    output logic          bus_oe,
    output logic          mem_dis,
    output logic          res_n,
    output logic          done
);
    // Select the injected byte for this cycle
    always_comb begin
        bus_dout = OP_NOP;
        if (state == ST_WAKE) begin
            if (int'(step) == 5)      bus_dout = ENTRY_VECTOR[7:0];
            else if (int'(step) == 6) bus_dout = ENTRY_VECTOR[15:8];
        end else if (state == ST_INJECT) begin
            case (int'(step))
                0:       bus_dout = OP_LDA_IMM;
                1:       bus_dout = hold_data;
                2:       bus_dout = OP_STA_ABS;
                3:       bus_dout = hold_addr[7:0];
                4:       bus_dout = hold_addr[15:8];
                default: bus_dout = OP_NOP;
            endcase
        end
    end

    // Own the bus in every boot cycle except the store's write cycle
    always_comb begin
        unique case (state)
            ST_PWR_RST, ST_WAKE, ST_IDLE_NOP: bus_oe = 1'b1;
            ST_INJECT:                        bus_oe = int'(step) != INJECT_LAST;
            default:                          bus_oe = 1'b0;
        endcase
        mem_dis = bus_oe;
        res_n   = !((state == ST_PWR_RST) || (state == ST_HANDOVER));
        done    = state == ST_RUN;
    end
endmodule

// File: rtl/boot_injector.sv
// Module boot_injector: top level of the ROM-less boot loader. It makes
// the CPU clock and feeds injected instructions until the last image
// record has been written, then resets the CPU onto its own RAM.
// Assumes the data bus is built from bus_dout/bus_oe by the surroundings.
module boot_injector
    import boot_inj_pkg::*;
#(
    parameter int          CLK_HALF_DIV = 2,
    parameter int          RESET_CYCLES = 3,
    parameter logic [15:0] ENTRY_VECTOR = 16'h0200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rec_valid,
    output logic        rec_ready,
    input  logic [15:0] rec_addr,
    input  logic [7:0]  rec_data,
    input  logic        rec_last,
    output logic        cpu_phi2,
    output logic        cpu_res_n,
    output logic        cpu_irq_n,
    output logic        cpu_nmi_n,
    input  logic        cpu_rwb,
    output logic [7:0]  bus_dout,
    output logic        bus_oe,
    output logic        mem_dis,
    output logic        ram_we_n,
    output logic        done
);
    localparam int SW = $clog2((RESET_CYCLES > 8) ? RESET_CYCLES : 8);

    logic          cyc_start;
    boot_state_t   state;
    logic [SW-1:0] step;
    logic [15:0]   hold_addr;
    logic [7:0]    hold_data;

    phase_clock #(.HALF_DIV(CLK_HALF_DIV)) i_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi2      (cpu_phi2),
        .cyc_start (cyc_start)
    );

    inject_seq #(.RESET_CYCLES(RESET_CYCLES)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .rec_valid (rec_valid),
        .rec_addr  (rec_addr),
        .rec_data  (rec_data),
        .rec_last  (rec_last),
        .rec_ready (rec_ready),
        .state     (state),
        .step      (step),
        .hold_addr (hold_addr),
        .hold_data (hold_data)
    );

    bus_driver #(.SW(SW), .ENTRY_VECTOR(ENTRY_VECTOR)) i_drv (
        .state     (state),
        .step      (step),
        .hold_addr (hold_addr),
        .hold_data (hold_data),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe),
        .mem_dis   (mem_dis),
        .res_n     (cpu_res_n),
        .done      (done)
    );

    // Qualify CPU writes with the clock-high phase and released memory
    assign ram_we_n  = !(cpu_phi2 && !cpu_rwb && !mem_dis && !bus_oe);
    // Interrupts are never raised by the loader
    assign cpu_irq_n = 1'b1;
    assign cpu_nmi_n = 1'b1;
endmodule

// File: rtl/boot_injector_chk.sv
// Module boot_injector_chk: temporal checks on the loader's ports,
// attached to every boot_injector instance by the bind below.
module boot_injector_chk #(
    parameter int CLK_HALF_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic rec_ready,
    input logic cpu_phi2,
    input logic cpu_res_n,
    input logic cpu_irq_n,
    input logic cpu_nmi_n,
    input logic bus_oe,
    input logic mem_dis,
    input logic ram_we_n,
    input logic done
);
    // R7
    oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_oe) |-> !cpu_phi2);
    // R7
    reset_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_res_n) |-> !cpu_phi2);
    // R8
    write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (cpu_phi2 && !bus_oe && !mem_dis));
    // R11
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ready |=> !rec_ready);
    // R11
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rec_ready);
    // R12
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    // R12
    done_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cpu_res_n && !mem_dis && !bus_oe));
    // R13
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_n && cpu_nmi_n);

    generate
        if (CLK_HALF_DIV > 1) begin : g_wide
            // R2
            phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(cpu_phi2) |=> $stable(cpu_phi2));
        end
    endgenerate
endmodule

bind boot_injector boot_injector_chk #(.CLK_HALF_DIV(CLK_HALF_DIV)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_ready (rec_ready),
    .cpu_phi2  (cpu_phi2),
    .cpu_res_n (cpu_res_n),
    .cpu_irq_n (cpu_irq_n),
    .cpu_nmi_n (cpu_nmi_n),
    .bus_oe    (bus_oe),
    .mem_dis   (mem_dis),
    .ram_we_n  (ram_we_n),
    .done      (done)
);

// File: tb/test_boot_injector.sv
`timescale 1ns/1ps
// Bench: acts as the CPU, decodes every bus cycle and checks it against
// sequences computed here from the requirements.
module test_boot_injector;
    localparam int          HALF = 2;
    localparam int          RC   = 3;
    localparam logic [15:0] VEC  = 16'h0200;
    localparam int          TCLK = 8;

    localparam int M_RST = 0, M_WAKE = 1, M_SLOT = 2, M_NOP2 = 3, M_DATA = 4,
                   M_OP2 = 5, M_LO = 6, M_HI = 7, M_WR = 8, M_HAND = 9, M_RUN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_valid = 1'b0;
    logic rec_ready;
    logic [15:0] rec_addr = '0;
    logic [7:0]  rec_data = '0;
    logic rec_last = 1'b0;
    logic cpu_phi2, cpu_res_n, cpu_irq_n, cpu_nmi_n;
    logic cpu_rwb = 1'b1;
    logic [7:0] bus_dout;
    logic bus_oe, mem_dis, ram_we_n, done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] r_addr [0:15];
    logic [7:0]  r_data [0:15];
    int          n_rec;
    int          gap_after;
    logic [15:0] e_addr [0:15];
    logic [7:0]  e_data [0:15];
    int          n_exp;

    always #(TCLK/2) clk = ~clk;

    boot_injector #(.CLK_HALF_DIV(HALF), .RESET_CYCLES(RC), .ENTRY_VECTOR(VEC)) i_boot_injector (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_addr(rec_addr), .rec_data(rec_data), .rec_last(rec_last),
        .cpu_phi2(cpu_phi2), .cpu_res_n(cpu_res_n), .cpu_irq_n(cpu_irq_n),
        .cpu_nmi_n(cpu_nmi_n), .cpu_rwb(cpu_rwb), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .mem_dis(mem_dis), .ram_we_n(ram_we_n), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Offer the records in order, with a pause after one of them (R10, R11)
    task automatic drive_records();
        for (int i = 0; i < n_rec; i++) begin
            rec_addr  = r_addr[i];
            rec_data  = r_data[i];
            rec_last  = (i == n_rec - 1);
            rec_valid = 1'b1;
            while (!rec_ready) @(negedge clk);
            @(negedge clk);
            rec_valid = 1'b0;
            if (i == gap_after) repeat (60) @(negedge clk);
        end
    endtask

    // Play the CPU and decode each bus cycle
    task automatic monitor_bus();
        int mode = M_RST;
        int cnt = 0;
        int wr_idx = 0;
        int nops = 0;
        logic [7:0] d_cap = '0, lo_cap = '0;
        time t_rise = 0, t_fall = 0;
        bit fin = 0;
        logic [7:0] s_d; logic s_oe, s_dis, s_res, s_we, s_done, s_rdy;
        while (!fin) begin
            @(negedge clk);
            cpu_rwb = (mode == M_WR) ? 1'b0 : 1'b1;
            #1;
            chk(ram_we_n == 1'b1, "R8", "strobe in low phase", ram_we_n, 1);
            @(posedge cpu_phi2);
            if (t_rise != 0) chk(($time - t_rise) == 2*HALF*TCLK, "R2", "phi2 period", int'($time - t_rise), 2*HALF*TCLK);
            if (t_fall != 0) chk(($time - t_fall) == HALF*TCLK, "R2", "phi2 low time", int'($time - t_fall), HALF*TCLK);
            t_rise = $time;
            @(negedge clk);
            s_d = bus_dout; s_oe = bus_oe; s_dis = mem_dis; s_res = cpu_res_n;
            s_we = ram_we_n; s_done = done; s_rdy = rec_ready;
            chk(cpu_irq_n && cpu_nmi_n, "R13", "interrupt lines", {cpu_irq_n, cpu_nmi_n}, 3);
            repeat (HALF - 1) @(negedge clk);
            chk({bus_dout, bus_oe, mem_dis, cpu_res_n} == {s_d, s_oe, s_dis, s_res}, "R7",
                "outputs in high phase", {bus_dout, bus_oe, mem_dis, cpu_res_n}, {s_d, s_oe, s_dis, s_res});
            case (mode)
                M_RST: begin
                    chk(s_res == 0 && s_oe && s_dis && s_d == 8'hEA, "R3", "power-up reset cycle",
                        {s_res, s_oe, s_dis, s_d}, {1'b0, 1'b1, 1'b1, 8'hEA});
                    cnt++;
                    if (cnt == RC) begin mode = M_WAKE; cnt = 0; end
                end
                M_WAKE: begin
                    logic [7:0] ex;
                    ex = (cnt < 5) ? 8'hEA : (cnt == 5) ? VEC[7:0] : VEC[15:8];
                    chk(s_res && s_oe && s_dis && s_d == ex, "R4", "wake-up cycle",
                        {s_res, s_oe, s_dis, s_d}, {1'b1, 1'b1, 1'b1, ex});
                    cnt++;
                    if (cnt == 7) mode = M_SLOT;
                end
                M_SLOT: begin
                    if (!s_res) begin
                        chk(!s_oe && !s_dis && !s_done, "R12", "handover release",
                            {s_oe, s_dis, s_done}, 0);
                        chk(wr_idx == n_exp, "R9", "written record count", wr_idx, n_exp);
                        mode = M_HAND; cnt = 1;
                    end else begin
                        chk(s_oe && s_dis && (s_d == 8'hA9 || s_d == 8'hEA), "R5", "slot opcode",
                            {s_oe, s_dis, s_d}, {1'b1, 1'b1, 8'hA9});
                        mode = (s_d == 8'hA9) ? M_DATA : M_NOP2;
                        if (s_d == 8'hEA) nops++;
                    end
                end
                M_NOP2: begin
                    chk(s_oe && s_dis && s_d == 8'hEA, "R9", "filler second cycle", s_d, 8'hEA);
                    mode = M_SLOT;
                end
                M_DATA: begin d_cap = s_d; mode = M_OP2;
                    chk(s_oe && s_dis, "R6", "bus owned on data cycle", {s_oe, s_dis}, 3); end
                M_OP2: begin
                    chk(s_d == 8'h8D && s_oe, "R5", "store opcode", s_d, 8'h8D);
                    mode = M_LO;
                end
                M_LO: begin lo_cap = s_d; mode = M_HI; end
                M_HI: begin
                    if (wr_idx < n_exp) begin
                        chk({s_d, lo_cap} == e_addr[wr_idx], "R5", "store address", {s_d, lo_cap}, e_addr[wr_idx]);
                        chk(d_cap == e_data[wr_idx], "R5", "store data", d_cap, e_data[wr_idx]);
                    end else chk(0, "R9", "unexpected write", {s_d, lo_cap}, 0);
                    mode = M_WR;
                end
                M_WR: begin
                    chk(!s_oe && !s_dis, "R6", "write cycle release", {s_oe, s_dis}, 0);
                    chk(s_we == 0, "R8", "strobe on write", s_we, 0);
                    wr_idx++;
                    mode = M_SLOT;
                end
                M_HAND: begin
                    if (cnt < RC) begin
                        chk(!s_res && !s_oe && !s_dis && !s_done, "R12", "handover reset",
                            {s_res, s_oe, s_dis, s_done}, 0);
                        cnt++;
                    end else begin
                        mode = M_RUN; cnt = 0;
                    end
                    if (mode == M_RUN) begin
                        chk(s_res && s_done && !s_dis && !s_oe, "R12", "run after handover",
                            {s_res, s_done, s_dis, s_oe}, 4'b1100);
                        cnt = 1;
                    end
                    chk(!s_rdy, "R11", "ready after last", s_rdy, 0);
                end
                default: begin
                    chk(s_res && s_done && !s_dis && !s_oe, "R12", "run state held",
                        {s_res, s_done, s_dis, s_oe}, 4'b1100);
                    chk(!s_rdy, "R11", "ready after last", s_rdy, 0);
                    cnt++;
                    if (cnt == 5) fin = 1;
                end
            endcase
            if (!fin) @(negedge cpu_phi2);
            t_fall = $time;
        end
        chk(nops > 0, "R10", "filler slots seen", nops, 1);
    endtask

    // Build the expected write list from the records, dropping the I/O page
    task automatic build_expect();
        n_exp = 0;
        for (int i = 0; i < n_rec; i++) begin
            if (r_addr[i][15:8] != 8'hFE) begin
                e_addr[n_exp] = r_addr[i];
                e_data[n_exp] = r_data[i];
                n_exp++;
            end
        end
    endtask

    initial begin
        for (int run = 0; run < 2; run++) begin
            if (run == 0) begin
                n_rec = 16; gap_after = 5;
                for (int i = 0; i < 16; i++) begin
                    r_addr[i] = 16'(i * 16'h1111);
                    r_data[i] = 8'((i * 37 + 5) & 8'hFF);
                end
                r_addr[3] = 16'hFE00; r_addr[7] = 16'hFEFF; r_addr[11] = 16'hFDFF;
                r_addr[12] = 16'hFF00; r_addr[13] = 16'hFFFA; r_addr[14] = 16'hFFFC;
                r_addr[15] = 16'hFFFE;
            end else begin
                n_rec = 6; gap_after = 2;
                for (int i = 0; i < 4; i++) begin
                    r_addr[i] = 16'hFE00 + 16'(i * 16'h40);
                    r_data[i] = 8'(8'h50 + i);
                end
                r_addr[4] = 16'hFFFD; r_data[4] = 8'hC3;
                r_addr[5] = 16'hFE55; r_data[5] = 8'h99;
            end
            build_expect();
            rst_n = 1'b0;
            rec_valid = 1'b0;
            cpu_rwb = 1'b1;
            repeat (5) @(negedge clk);
            chk(cpu_res_n == 0 && mem_dis && !done && !cpu_phi2 && !rec_ready, "R1", "reset state",
                {cpu_res_n, mem_dis, done, cpu_phi2, rec_ready}, 5'b01000);
            rst_n = 1'b1;
            fork
                drive_records();
                monitor_bus();
            join
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule